// File: doc/BRIEF.md
# Slot Power Limit Message Handler

This block deals with the slot power limit message at both ends of a link in a PCIe-style switch. It has two sides. The upstream side takes a received message, modelled as a single-cycle valid strobe with a two-byte payload. It keeps the power limit fields carried in that payload in two captured registers. These registers stand for the captured power limit fields of the port's device capability register.

The downstream side holds the slot capability register's power limit fields. A configuration write port loads them. The block decides when an outbound message carrying those fields must be sent. One case is a configuration write to the register while the link is up. The other is the link becoming operational. The outbound message is a request/acknowledge transaction. The request stays high with a stable payload until the receiver accepts it.

Packet framing, CRC and the physical layer are outside this block.

Top module: `slot_pwr_msg_ctl`

## Requirements
- R1: When `rx_valid` is sampled high at a clock edge, `cap_lim_lo` takes payload byte 0 (`rx_payload[7:0]`) after that edge.
- R2: When `rx_valid` is sampled high, `cap_lim_hi` takes payload byte 1 bits 1:0 (`rx_payload[9:8]`). Bits `rx_payload[15:10]` have no effect on any output.
- R3: `cap_lim_lo` and `cap_lim_hi` are zero after reset. They change only at an edge where `rx_valid` is high.
- R4: A configuration write (`cfg_we` high) sampled while `link_up` is high raises `tx_req` after that same edge.
- R5: A rise of `link_up` raises `tx_req` after the first edge at which `link_up` is sampled high. A `link_up` that is already high when reset is released counts as a rise.
- R6: A configuration write sampled while `link_up` is low updates the slot register and raises no request. A request is only ever raised at an edge where `link_up` is high.
- R7: A configuration write and a link rise at the same edge produce exactly one message, and that message carries the newly written values.
- R8: Once raised, `tx_req` stays high with an unchanged `tx_payload` until `tx_ack` is sampled high. It then falls after that edge, unless a new trigger arrives at the same edge.
- R9: A trigger that arrives while a request is pending merges into that request, and `tx_payload` is refreshed to the latest register contents.
- R10: `tx_payload` carries the register's 8-bit field in bits 7:0 and its 2-bit field in bits 9:8. Bits 15:10 are zero.
- R11: After reset, `tx_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Received power limit message strobe |
| rx_payload | input | 16 | Received message payload, byte 0 in bits 7:0 |
| cap_lim_lo | output | 8 | Captured 8-bit power limit field |
| cap_lim_hi | output | 2 | Captured 2-bit power limit field |
| cfg_we | input | 1 | Configuration write strobe for the slot register |
| cfg_lim_lo | input | 8 | Write data, 8-bit power limit field |
| cfg_lim_hi | input | 2 | Write data, 2-bit power limit field |
| link_up | input | 1 | Link operational status |
| tx_req | output | 1 | Outbound message request |
| tx_payload | output | 16 | Outbound message payload |
| tx_ack | input | 1 | Outbound message accepted |

## Verification
The bench drives a received payload whose upper byte-1 bits are all set. A capture that took the whole byte would then show a wrong 2-bit field. It performs a write while the link is down and expects no request. It then checks that the following link rise sends the written value; a design that dropped or ignored the write would send stale data or nothing. The bench also fires a write together with a link rise at the same edge. A design that treats these as two events sends two messages, and one that sends the old register contents fails the payload compare. Finally, two writes land while acknowledge is withheld. The bench requires a single held request carrying the second value, which catches designs that queue duplicates or freeze the first payload.

// File: rtl/spl_pkg.sv
package spl_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_PEND = 1'b1
  } tx_state_t;
endpackage

// File: rtl/spl_capture.sv
module spl_capture #(
  parameter int LO_W  = 8,
  parameter int HI_W  = 2,
  parameter int PAY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [PAY_W-1:0] rx_payload,
  output logic [LO_W-1:0]  cap_lo,
  output logic [HI_W-1:0]  cap_hi
);
  localparam int HI_BASE = spl_pkg::BYTE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_lo <= '0;
      cap_hi <= '0;
    end else if (rx_valid) begin
      cap_lo <= rx_payload[LO_W-1:0];
      cap_hi <= rx_payload[HI_BASE +: HI_W];
    end
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> ($stable(cap_lo) && $stable(cap_hi))); // R3

  AST_CAP_HI_BITS: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> (cap_hi == $past(rx_payload[HI_BASE +: HI_W]))); // R2
endmodule

// File: rtl/spl_slot_reg.sv
module spl_slot_reg #(
  parameter int LO_W = 8,
  parameter int HI_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [LO_W-1:0] cfg_lo,
  input  logic [HI_W-1:0] cfg_hi,
  output logic [LO_W-1:0] next_lo,
  output logic [HI_W-1:0] next_hi
);
  logic [LO_W-1:0] reg_lo;
  logic [HI_W-1:0] reg_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_lo <= '0;
      reg_hi <= '0;
    end else if (cfg_we) begin
      reg_lo <= cfg_lo;
      reg_hi <= cfg_hi;
    end
  end

  // Write data bypasses the register so that a send at the write edge
  // carries the value being written.
  always_comb begin
    next_lo = cfg_we ? cfg_lo : reg_lo;
    next_hi = cfg_we ? cfg_hi : reg_hi;
  end
endmodule

// File: rtl/spl_tx_sched.sv
module spl_tx_sched #(
  parameter int LO_W  = 8,
  parameter int HI_W  = 2,
  parameter int PAY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_up,
  input  logic             cfg_we,
  input  logic [LO_W-1:0]  src_lo,
  input  logic [HI_W-1:0]  src_hi,
  input  logic             tx_ack,
  output logic             tx_req,
  output logic [PAY_W-1:0] tx_payload
);
  import spl_pkg::*;

  localparam int HI_BASE = BYTE_W;

  tx_state_t        state;
  logic             link_q;
  logic             link_rise;
  logic             trig;
  logic [PAY_W-1:0] frame;

  always_comb begin
    link_rise = link_up && !link_q;
    trig      = (cfg_we && link_up) || link_rise;
    frame                       = '0;
    frame[LO_W-1:0]             = src_lo;
    frame[HI_BASE +: HI_W]      = src_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      link_q     <= 1'b0;
      state      <= TX_IDLE;
      tx_payload <= '0;
    end else begin
      link_q <= link_up;
      if (trig) begin
        state      <= TX_PEND;
        tx_payload <= frame;
      end else if (state == TX_PEND && tx_ack) begin
        state <= TX_IDLE;
      end
    end
  end

  assign tx_req = (state == TX_PEND);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_ack) |=> tx_req); // R8

  AST_PAY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_ack && !trig) |=> $stable(tx_payload)); // R8

  AST_SEND_NEEDS_LINK: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_req) |-> link_q); // R6

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> (tx_payload[PAY_W-1:HI_BASE+HI_W] == '0)); // R10
endmodule

// File: rtl/slot_pwr_msg_ctl.sv
module slot_pwr_msg_ctl #(
  parameter int LO_W = 8,
  parameter int HI_W = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic [15:0] rx_payload,
  output logic [LO_W-1:0] cap_lim_lo,
  output logic [HI_W-1:0] cap_lim_hi,
  input  logic        cfg_we,
  input  logic [LO_W-1:0] cfg_lim_lo,
  input  logic [HI_W-1:0] cfg_lim_hi,
  input  logic        link_up,
  output logic        tx_req,
  output logic [15:0] tx_payload,
  input  logic        tx_ack
);
  localparam int PAY_W = 2 * spl_pkg::BYTE_W;

  logic [LO_W-1:0] src_lo;
  logic [HI_W-1:0] src_hi;

  spl_capture #(.LO_W(LO_W), .HI_W(HI_W), .PAY_W(PAY_W)) u_capture (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_payload (rx_payload),
    .cap_lo     (cap_lim_lo),
    .cap_hi     (cap_lim_hi)
  );

  spl_slot_reg #(.LO_W(LO_W), .HI_W(HI_W)) u_slot_reg (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we),
    .cfg_lo  (cfg_lim_lo),
    .cfg_hi  (cfg_lim_hi),
    .next_lo (src_lo),
    .next_hi (src_hi)
  );

  spl_tx_sched #(.LO_W(LO_W), .HI_W(HI_W), .PAY_W(PAY_W)) u_tx_sched (
    .clk        (clk),
    .rst        (rst),
    .link_up    (link_up),
    .cfg_we     (cfg_we),
    .src_lo     (src_lo),
    .src_hi     (src_hi),
    .tx_ack     (tx_ack),
    .tx_req     (tx_req),
    .tx_payload (tx_payload)
  );
endmodule

// File: tb/slot_pwr_msg_ctl_tb.sv
module slot_pwr_msg_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [15:0] rx_payload = '0;
  logic [7:0]  cap_lim_lo;
  logic [1:0]  cap_lim_hi;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_lim_lo = '0;
  logic [1:0]  cfg_lim_hi = '0;
  logic        link_up = 1'b0;
  logic        tx_req;
  logic [15:0] tx_payload;
  logic        tx_ack = 1'b0;

  int          n_checks = 0;
  int          n_fail   = 0;
  int          n_msgs   = 0;
  int          cyc      = 0;
  bit          ack_en   = 1'b1;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  slot_pwr_msg_ctl u_dut (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_payload (rx_payload),
    .cap_lim_lo (cap_lim_lo),
    .cap_lim_hi (cap_lim_hi),
    .cfg_we     (cfg_we),
    .cfg_lim_lo (cfg_lim_lo),
    .cfg_lim_hi (cfg_lim_hi),
    .link_up    (link_up),
    .tx_req     (tx_req),
    .tx_payload (tx_payload),
    .tx_ack     (tx_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] frame(input logic [7:0] lo, input logic [1:0] hi);
    return {6'b0, hi, lo};
  endfunction

  task automatic expect_msg(input logic [15:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // Monitor: acknowledges a request and pops the scoreboard in the same cycle
  always @(negedge clk) begin
    if (rst) begin
      tx_ack = 1'b0;
    end else if (tx_req && ack_en) begin
      tx_ack = 1'b1;
      n_msgs++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected message", tx_payload, 16'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(tx_payload == e, t, tx_payload, e);
      end
    end else begin
      tx_ack = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      check(1'b0, "watchdog", 16'(cyc), 16'(WATCHDOG));
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic cfg_write(input logic [7:0] lo, input logic [1:0] hi);
    @(negedge clk);
    cfg_we = 1'b1; cfg_lim_lo = lo; cfg_lim_hi = hi;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rx_msg(input logic [15:0] p);
    @(negedge clk);
    rx_valid = 1'b1; rx_payload = p;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, tag, 16'(exp_q.size()), 16'h0);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 / R3 reset state
    check(tx_req == 1'b0, "R11 tx_req after reset", 16'(tx_req), 16'h0);
    check({cap_lim_hi, cap_lim_lo} == 10'h0, "R3 capture reset", 16'({cap_lim_hi, cap_lim_lo}), 16'h0);

    // R1 / R2 capture, upper bits of byte 1 set
    rx_msg(16'hFEA5);
    check(cap_lim_lo == 8'hA5, "R1 capture byte0", 16'(cap_lim_lo), 16'hA5);
    check(cap_lim_hi == 2'b10, "R2 capture byte1[1:0]", 16'(cap_lim_hi), 16'h2);
    rx_msg(16'h0103);
    check(cap_lim_lo == 8'h03, "R1 capture byte0 second", 16'(cap_lim_lo), 16'h03);
    check(cap_lim_hi == 2'b01, "R2 capture byte1 second", 16'(cap_lim_hi), 16'h1);

    // R3 no change without strobe
    @(negedge clk); rx_payload = 16'hFFFF;
    repeat (3) @(negedge clk);
    check({cap_lim_hi, cap_lim_lo} == 10'h103, "R3 hold without strobe", 16'({cap_lim_hi, cap_lim_lo}), 16'h103);

    // R6 write while link down: no request
    cfg_write(8'h11, 2'b01);
    repeat (3) @(negedge clk);
    check(tx_req == 1'b0, "R6 no send while down", 16'(tx_req), 16'h0);

    // R5 link rise sends register contents (written while down), R10 format
    expect_msg(frame(8'h11, 2'b01), "R5 R10 link rise payload");
    base = n_msgs;
    link_up = 1'b1;
    drain("R5 message delivered");
    check(n_msgs - base == 1, "R5 single message", 16'(n_msgs - base), 16'h1);

    // R4 write while up
    expect_msg(frame(8'h40, 2'b11), "R4 write while up payload");
    cfg_write(8'h40, 2'b11);
    drain("R4 message delivered");

    // R7 write and rise at the same edge
    link_up = 1'b0;
    repeat (3) @(negedge clk);
    expect_msg(frame(8'h22, 2'b10), "R7 merged new values");
    base = n_msgs;
    @(negedge clk);
    link_up = 1'b1; cfg_we = 1'b1; cfg_lim_lo = 8'h22; cfg_lim_hi = 2'b10;
    @(negedge clk);
    cfg_we = 1'b0;
    drain("R7 message delivered");
    check(n_msgs - base == 1, "R7 exactly one message", 16'(n_msgs - base), 16'h1);

    // R8 / R9 hold and merge while pending
    ack_en = 1'b0;
    base = n_msgs;
    cfg_write(8'h55, 2'b01);
    cfg_write(8'h66, 2'b10);
    repeat (4) @(negedge clk);
    check(tx_req == 1'b1, "R8 request held without ack", 16'(tx_req), 16'h1);
    check(tx_payload == frame(8'h66, 2'b10), "R9 payload refreshed", tx_payload, frame(8'h66, 2'b10));
    expect_msg(frame(8'h66, 2'b10), "R9 merged message");
    ack_en = 1'b1;
    drain("R9 message delivered");
    check(n_msgs - base == 1, "R9 one merged message", 16'(n_msgs - base), 16'h1);
    check(tx_req == 1'b0, "R8 request drops after ack", 16'(tx_req), 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule